// File: doc/BRIEF.md
# Converter Self-Calibration Trigger Sequencer

This block decides when a data converter runs its self-calibration. After the power-on reset lifts, a power-up delay counter runs. When it expires, a calibration starts on its own. A select input picks one of two delay lengths, and a power-down level freezes the counter until power-down drops.

Software can ask for a calibration in two ways. The first is a request pin that must be held low for a minimum time and then high for a minimum time. The second is a register write with the trigger bit set. A calibration cannot start while power-down is asserted, and asserting power-down during a run aborts it.

The analog trimming is outside this block. A run counter of programmable length stands in for it, and an external done input can end a run early. All pins are plain level or strobe controls. There is no streaming interface, so no valid/ready back-pressure applies.

Top module: `cal_seq_top`

## Requirements
- R1: During and right after reset, `cal_busy` and `cal_done` are 0.
- R2: With `pwr_down` low and `cal_req_n` low at power-up, `cal_busy` first reads 1 in the cycle after the (D+1)-th rising clock edge following reset release. D is `DLY_SHORT` when `dly_sel` is 0 and `DLY_LONG` when it is 1.
- R3: Every clock edge that sees `pwr_down` high before the power-up delay expires postpones the automatic calibration by exactly one cycle.
- R4: If the request pin is sampled low on at least `LOW_CYC` consecutive edges and then high on `HIGH_CYC` consecutive edges, a calibration starts. `cal_busy` reads 1 after the (`HIGH_CYC`+1)-th edge counted from the rising pin transition.
- R5: A low phase shorter than `LOW_CYC`, or a high phase shorter than `HIGH_CYC`, starts nothing. After a high phase that was too short, a complete new low phase is needed.
- R6: If `cal_req_n` is high on the first edge after reset, the automatic power-up calibration never runs. The first calibration comes from a qualified pin sequence or a register write.
- R7: A write strobe with `reg_addr` = 0 and `reg_wdata` bit 15 = 1 makes `cal_busy` read 1 after that edge. Writes to another address, or with bit 15 = 0, leave `cal_busy` at 0.
- R8: While `pwr_down` is high, no request starts a calibration. Such requests are discarded and do not take effect when power-down drops.
- R9: A run with no done input and no power-down keeps `cal_busy` high for exactly `RUN_CYC` cycles. `cal_done` is high for one cycle: the first cycle in which `cal_busy` is low again.
- R10: If `cal_done_in` is high on an edge during a run, `cal_busy` falls after that edge and `cal_done` pulses.
- R11: If `pwr_down` is high on an edge during a run, the run aborts. `cal_busy` falls with no `cal_done` pulse, and the block stays idle until a new request arrives.
- R12: A request that arrives during a run neither extends nor restarts the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter control clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cal_req_n | input | 1 | Calibration request pin (low phase then high phase) |
| pwr_down | input | 1 | Power-down level; blocks and aborts calibration |
| dly_sel | input | 1 | Power-up delay select: 0 short, 1 long |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register write address |
| reg_wdata | input | DATA_W | Register write data; bit 15 of address 0 triggers |
| cal_done_in | input | 1 | Early end of calibration from the trimming logic |
| cal_busy | output | 1 | Calibration running |
| cal_done | output | 1 | One-cycle pulse on normal completion |

## Verification
A wrong internal count shows up as a rising edge of `cal_busy` that arrives early or late. The bench therefore measures the rise to the exact cycle against the delay, the power-down hold time and the pin phase lengths. A qualifier that stays armed when it should have disarmed starts a run within `HIGH_CYC` cycles after a disqualifying sequence, which the pin sweep catches. A run FSM stuck in the wrong state shows as a busy width other than `RUN_CYC`, or as a missing or extra `cal_done` pulse, within one run length.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic {
    RS_IDLE = 1'b0,
    RS_RUN  = 1'b1
  } run_state_t;

  typedef struct packed {
    logic powerup;
    logic pin;
    logic regw;
  } cal_req_t;

endpackage

// File: rtl/cal_pu_timer.sv
module cal_pu_timer #(
  parameter int DLY_SHORT = 256,
  parameter int DLY_LONG  = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic dly_sel,
  input  logic pin_level,
  output logic fire
);
  localparam int DMAX = (DLY_LONG > DLY_SHORT) ? DLY_LONG : DLY_SHORT;
  localparam int CW   = $clog2(DMAX + 1);
  localparam logic [CW-1:0] LAST_S = CW'(DLY_SHORT - 1);
  localparam logic [CW-1:0] LAST_L = CW'(DLY_LONG - 1);

  logic [CW-1:0] cnt;
  logic          expired;
  logic          sampled;
  logic          hold;
  logic          hold_eff;
  logic [CW-1:0] last;

  assign last     = dly_sel ? LAST_L : LAST_S;
  assign hold_eff = sampled ? hold : pin_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      expired <= 1'b0;
      sampled <= 1'b0;
      hold    <= 1'b0;
      fire    <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (!sampled) begin
        sampled <= 1'b1;
        hold    <= pin_level;
      end
      if (!expired && !pwr_down) begin
        if (cnt >= last) begin
          expired <= 1'b1;
          fire    <= !hold_eff;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cal_pin_qual.sv
module cal_pin_qual #(
  parameter int LOW_CYC  = 16,
  parameter int HIGH_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fire
);
  localparam int LW = $clog2(LOW_CYC + 1);
  localparam int HW = $clog2(HIGH_CYC + 1);
  localparam logic [LW-1:0] LOW_MAX   = LW'(LOW_CYC);
  localparam logic [HW-1:0] HIGH_LAST = HW'(HIGH_CYC - 1);

  logic [LW-1:0] low_cnt;
  logic [HW-1:0] high_cnt;
  logic          armed;

  assign armed = (low_cnt == LOW_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= '0;
      fire     <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (!pin) begin
        high_cnt <= '0;
        if (high_cnt != '0) begin
          low_cnt <= LW'(1);
        end else if (!armed) begin
          low_cnt <= low_cnt + 1'b1;
        end
      end else if (armed) begin
        if (high_cnt == HIGH_LAST) begin
          fire     <= 1'b1;
          low_cnt  <= '0;
          high_cnt <= '0;
        end else begin
          high_cnt <= high_cnt + 1'b1;
        end
      end else begin
        low_cnt  <= '0;
        high_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/cal_run_ctrl.sv
module cal_run_ctrl
  import cal_seq_pkg::*;
#(
  parameter int RUN_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic pwr_down,
  input  logic done_in,
  output logic busy,
  output logic done
);
  localparam int RW = $clog2(RUN_CYC + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_CYC - 1);

  run_state_t    state;
  logic [RW-1:0] cnt;

  assign busy = (state == RS_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RS_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        RS_IDLE: begin
          if (req && !pwr_down) begin
            state <= RS_RUN;
            cnt   <= '0;
          end
        end
        RS_RUN: begin
          if (pwr_down) begin
            state <= RS_IDLE;
          end else if (done_in || cnt == RUN_LAST) begin
            state <= RS_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top
  import cal_seq_pkg::*;
#(
  parameter int LOW_CYC   = 16,
  parameter int HIGH_CYC  = 16,
  parameter int DLY_SHORT = 256,
  parameter int DLY_LONG  = 1024,
  parameter int RUN_CYC   = 64,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int CTRL_ADDR = 0,
  parameter int TRIG_BIT  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_req_n,
  input  logic              pwr_down,
  input  logic              dly_sel,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              cal_done_in,
  output logic              cal_busy,
  output logic              cal_done
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  cal_req_t reqs;
  logic     any_req;
  logic     unused_wdata;

  assign unused_wdata = ^reg_wdata;

  cal_pu_timer #(
    .DLY_SHORT(DLY_SHORT),
    .DLY_LONG (DLY_LONG)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_down (pwr_down),
    .dly_sel  (dly_sel),
    .pin_level(cal_req_n),
    .fire     (reqs.powerup)
  );

  cal_pin_qual #(
    .LOW_CYC (LOW_CYC),
    .HIGH_CYC(HIGH_CYC)
  ) u_qual (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (cal_req_n),
    .fire (reqs.pin)
  );

  assign reqs.regw = reg_wr_en && (reg_addr == CTRL_A) && reg_wdata[TRIG_BIT];
  assign any_req   = |reqs;

  cal_run_ctrl #(
    .RUN_CYC(RUN_CYC)
  ) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (any_req),
    .pwr_down(pwr_down),
    .done_in (cal_done_in),
    .busy    (cal_busy),
    .done    (cal_done)
  );
endmodule

// File: rtl/cal_seq_checker.sv
module cal_seq_checker #(
  parameter int RUN_CYC = 64
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_down,
  input logic wr_hit,
  input logic cal_done_in,
  input logic cal_busy,
  input logic cal_done
);
  localparam int CW = $clog2(RUN_CYC + 2);
  logic [CW-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else if (!cal_busy) busy_len <= '0;
    else if (busy_len != CW'(RUN_CYC + 1)) busy_len <= busy_len + 1'b1;
  end

  a_r9_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (!cal_busy && $past(cal_busy)));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done);
  a_r9_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> (busy_len < CW'(RUN_CYC)));
  a_r8_no_start_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy && pwr_down) |=> !cal_busy);
  a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && pwr_down) |=> (!cal_busy && !cal_done));
  a_r10_done_in: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && cal_done_in && !pwr_down) |=> (!cal_busy && cal_done));
  a_r7_reg_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy && !pwr_down && wr_hit) |=> cal_busy);
endmodule

bind cal_seq_top cal_seq_checker #(
  .RUN_CYC(RUN_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_down   (pwr_down),
  .wr_hit     (reg_wr_en && (reg_addr == ADDR_W'(CTRL_ADDR)) && reg_wdata[TRIG_BIT]),
  .cal_done_in(cal_done_in),
  .cal_busy   (cal_busy),
  .cal_done   (cal_done)
);

// File: tb/cal_seq_top_test.sv
module cal_seq_top_test;
  localparam int LOWC = 4;
  localparam int HIGHC = 3;
  localparam int DS = 20;
  localparam int DL = 40;
  localparam int RUN = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_req_n = 1'b0;
  logic pwr_down = 1'b0;
  logic dly_sel = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic cal_done_in = 1'b0;
  logic cal_busy;
  logic cal_done;

  int nvec = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cal_seq_top #(
    .LOW_CYC(LOWC), .HIGH_CYC(HIGHC), .DLY_SHORT(DS), .DLY_LONG(DL), .RUN_CYC(RUN)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cal_req_n(cal_req_n), .pwr_down(pwr_down),
    .dly_sel(dly_sel), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cal_done_in(cal_done_in),
    .cal_busy(cal_busy), .cal_done(cal_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic pin, input logic pd, input logic ds);
    @(negedge clk);
    rst_n = 1'b0;
    cal_req_n = pin;
    pwr_down = pd;
    dly_sel = ds;
    reg_wr_en = 1'b0;
    cal_done_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic first_busy(input int maxn, output int n);
    n = -1;
    for (int i = 1; i <= maxn; i++) begin
      step();
      if (cal_busy && n < 0) n = i;
      if (n >= 0) break;
    end
  endtask

  task automatic run_len(output int len, output int dfall, output int dafter);
    len = 1;
    for (int i = 0; i < 4 * RUN; i++) begin
      step();
      if (cal_busy) len++;
      else break;
    end
    dfall = int'(cal_done);
    step();
    dafter = int'(cal_done);
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
    reg_wr_en = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    step();
    reg_wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int n, len, df, da, seen, busy_any, done_any;

    // R1 R2 R9: automatic calibration after each delay length
    for (int ds = 0; ds < 2; ds++) begin
      do_reset(1'b0, 1'b0, ds[0]);
      check(!cal_busy && !cal_done, "R1", int'({cal_busy, cal_done}), 0);
      first_busy(DL + 10, n);
      check(n == ((ds != 0) ? DL : DS) + 1, "R2", n, ((ds != 0) ? DL : DS) + 1);
      run_len(len, df, da);
      check(len == RUN, "R9 length", len, RUN);
      check(df == 1 && da == 0, "R9 done pulse", df * 2 + da, 2);
    end

    // R3: power-down held P edges postpones by P
    for (int p = 1; p <= 7; p += 3) begin
      do_reset(1'b0, 1'b1, 1'b0);
      repeat (p) step();
      check(!cal_busy, "R3 frozen", int'(cal_busy), 0);
      pwr_down = 1'b0;
      first_busy(DS + 10, n);
      check(n == DS + 1, "R3", n, DS + 1);
    end

    // R6 R4 R5: sweep pin phase lengths
    for (int l = 1; l <= LOWC + 2; l++) begin
      for (int h = 1; h <= HIGHC + 2; h++) begin
        do_reset(1'b1, 1'b0, 1'b0);
        busy_any = 0;
        for (int i = 0; i < DS + 5; i++) begin
          step();
          if (cal_busy) busy_any = 1;
        end
        check(busy_any == 0, "R6 withheld", busy_any, 0);
        cal_req_n = 1'b0;
        repeat (l) step();
        cal_req_n = 1'b1;
        seen = -1;
        for (int k = 1; k <= h + 1 + RUN + 4; k++) begin
          if (k == h + 1) cal_req_n = 1'b0;
          if (k == h + 2) cal_req_n = 1'b1;
          step();
          if (cal_busy && seen < 0) seen = k;
        end
        if (l >= LOWC && h >= HIGHC)
          check(seen == HIGHC + 1, "R4", seen, HIGHC + 1);
        else
          check(seen == -1, "R5", seen, -1);
      end
    end

    // R7: register trigger decode
    do_reset(1'b1, 1'b0, 1'b0);
    repeat (3) step();
    reg_write(4'd1, 16'h8000);
    repeat (3) step();
    check(!cal_busy, "R7 other address", int'(cal_busy), 0);
    reg_write(4'd0, 16'h7FFF);
    repeat (3) step();
    check(!cal_busy, "R7 bit15 clear", int'(cal_busy), 0);
    reg_write(4'd0, 16'h8000);
    check(cal_busy, "R7 trigger", int'(cal_busy), 1);

    // R12: request during run is ignored
    step();
    step();
    reg_write(4'd0, 16'hFFFF);
    len = 4;
    for (int i = 0; i < 4 * RUN; i++) begin
      if (!cal_busy) break;
      step();
      if (cal_busy) len++;
    end
    check(len == RUN, "R12 length", len, RUN);
    check(cal_done, "R12 done", int'(cal_done), 1);
    repeat (4) step();
    check(!cal_busy, "R12 no restart", int'(cal_busy), 0);

    // R8: requests under power-down discarded
    pwr_down = 1'b1;
    step();
    reg_write(4'd0, 16'h8000);
    busy_any = int'(cal_busy);
    repeat (3) begin step(); if (cal_busy) busy_any = 1; end
    pwr_down = 1'b0;
    repeat (5) begin step(); if (cal_busy) busy_any = 1; end
    check(busy_any == 0, "R8", busy_any, 0);

    // R10: early end from done input
    reg_write(4'd0, 16'h8000);
    step();
    step();
    cal_done_in = 1'b1;
    step();
    cal_done_in = 1'b0;
    check(!cal_busy && cal_done, "R10", int'({cal_busy, cal_done}), 1);

    // R11: abort by power-down
    step();
    reg_write(4'd0, 16'h8000);
    step();
    pwr_down = 1'b1;
    step();
    check(!cal_busy && !cal_done, "R11 abort", int'({cal_busy, cal_done}), 0);
    pwr_down = 1'b0;
    busy_any = 0;
    done_any = 0;
    repeat (RUN + 5) begin
      step();
      if (cal_busy) busy_any = 1;
      if (cal_done) done_any = 1;
    end
    check(busy_any == 0 && done_any == 0, "R11 idle", busy_any + done_any, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule